// File: doc/BRIEF.md
# Prioritised Eight-Line Interrupt Controller

The controller watches eight device request lines, records each rising edge as a pending request, and filters the pending set through a per-line mask. Among the surviving requests the lowest-numbered line wins, provided no line of equal or higher priority is already being serviced. When a winner exists the controller raises a single interrupt output towards the processor. It then serves the processor's two-pulse acknowledge exchange. The first pulse lowers the interrupt, retires the pending request and marks the line in service. The second pulse places the line's vector on an 8-bit bus.

Software uses a small write-only register port to load the mask and the vector base, and to end service on chosen lines. The vector is the line number added to the base. The base resets to 32, so device vectors sit above the low range kept for processor exceptions. If the serviced line has gone low by the time the second pulse begins, the controller returns base + 7 as a spurious vector and releases the line's in-service bit itself.

The handshake is a five-state machine. IDLE moves to ASSERT when a winner exists. ASSERT moves to PULSE1 on the rising edge of the acknowledge. PULSE1 moves to GAP when the acknowledge falls. GAP moves to PULSE2 on the next rising edge. PULSE2 returns to IDLE when the acknowledge falls.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_out is 0, vec_bus is 0, every line is unmasked and the vector base is 32.
- R2: A 0-to-1 transition on irq_req[i] makes line i pending. A line held high does not become pending again until it has been low for at least one cycle.
- R3: A pending line whose mask bit is 1 does not raise irq_out. It stays pending, and clearing its mask bit later raises irq_out.
- R4: When several unmasked lines are pending, line 0 has the highest priority and line 7 the lowest. The lowest-numbered line is serviced first.
- R5: irq_out goes high when an eligible winner exists. The rising edge of irq_ack while irq_out is high lowers irq_out, clears the winner's pending bit and sets its in-service bit. The in-service set never grows while irq_out is low.
- R6: vec_bus carries base + line only while irq_ack is high during the second pulse. It is 0 at all other times, including between the two pulses.
- R7: If the serviced line is low when the second pulse begins, vec_bus carries base + 7 and the line's in-service bit is cleared without an end-of-service write.
- R8: While line k is in service, pending requests on lines k..7 do not raise irq_out. A pending request on a line below k does raise it, so service can nest.
- R9: A write to reg_addr 2 clears the in-service bit of every line i for which reg_wdata[i] is 1.
- R10: A write to reg_addr 0 loads the mask, where bit i set masks line i. A write to reg_addr 1 loads the vector base. A write to reg_addr 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 8 | Device request lines, captured on rising edges |
| irq_ack | input | 1 | Processor acknowledge; each high period is one pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mask, 1 base, 2 end of service |
| reg_wdata | input | 8 | Register write data |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_bus | output | 8 | Vector bus, nonzero only during the second pulse |

## Verification
The bench nests a higher-priority line inside an active service and re-triggers a line while it is still in service. A design that ignored the in-service set would raise the interrupt for the blocked lines, and one that dropped pending edges during service would never deliver the re-triggered request.

It unmasks three pending lines at once and expects their vectors in strict line order. A design with inverted priority would return them reversed.

It drops a request between the two pulses and expects the spurious vector. It then expects a lower-priority line to be serviced at once, which fails if the spurious path leaves the in-service bit set.

The bus is sampled between pulses, where a design that drove it early would show a nonzero value.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    typedef enum logic [2:0] {
        HS_IDLE,
        HS_ASSERT,
        HS_PULSE1,
        HS_GAP,
        HS_PULSE2
    } hs_state_e;

    localparam logic [1:0] REG_MASK = 2'd0;
    localparam logic [1:0] REG_BASE = 2'd1;
    localparam logic [1:0] REG_EOS  = 2'd2;

endpackage

// File: rtl/pic_edge_capture.sv
module pic_edge_capture #(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_i,
    input  logic [N_LINES-1:0] clr_i,
    output logic [N_LINES-1:0] pend_o
);

    logic [N_LINES-1:0] req_q;

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_i;
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic pend_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                     pend_q <= 1'b0;
            else if (req_i[g] && !req_q[g]) pend_q <= 1'b1;
            else if (clr_i[g])              pend_q <= 1'b0;
        end
        assign pend_o[g] = pend_q;
    end

endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve #(
    parameter int N_LINES = 8,
    localparam int LINE_W = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] pend_i,
    input  logic [N_LINES-1:0] mask_i,
    input  logic [N_LINES-1:0] isr_i,
    output logic               valid_o,
    output logic [LINE_W-1:0]  line_o
);

    logic [N_LINES-1:0] elig;
    logic               found;
    logic               blocked;

    assign elig = pend_i & ~mask_i;

    always_comb begin
        found  = 1'b0;
        line_o = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found  = 1'b1;
                line_o = LINE_W'(i);
            end
        end
    end

    always_comb begin
        blocked = 1'b0;
        for (int i = 0; i < N_LINES; i++) begin
            if (isr_i[i] && (LINE_W'(i) <= line_o)) blocked = 1'b1;
        end
    end

    assign valid_o = found && !blocked;

endmodule

// File: rtl/pic_regs.sv
module pic_regs
    import prio_irq_pkg::*;
#(
    parameter int N_LINES  = 8,
    parameter int VEC_W    = 8,
    parameter int DEF_BASE = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [1:0]         addr_i,
    input  logic [VEC_W-1:0]   wdata_i,
    input  logic [N_LINES-1:0] isr_set_i,
    input  logic [N_LINES-1:0] isr_clr_i,
    output logic [N_LINES-1:0] mask_o,
    output logic [VEC_W-1:0]   base_o,
    output logic [N_LINES-1:0] isr_o
);

    logic [N_LINES-1:0] eos_bits;

    assign eos_bits = (wr_i && addr_i == REG_EOS) ? wdata_i[N_LINES-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= '0;
            base_o <= VEC_W'(DEF_BASE);
            isr_o  <= '0;
        end else begin
            if (wr_i && addr_i == REG_MASK) mask_o <= wdata_i[N_LINES-1:0];
            if (wr_i && addr_i == REG_BASE) base_o <= wdata_i;
            isr_o <= (isr_o & ~isr_clr_i & ~eos_bits) | isr_set_i;
        end
    end

endmodule

// File: rtl/pic_hs_fsm.sv
module pic_hs_fsm
    import prio_irq_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int VEC_W   = 8,
    localparam int LINE_W = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ack_i,
    input  logic [N_LINES-1:0] req_i,
    input  logic               win_valid_i,
    input  logic [LINE_W-1:0]  win_line_i,
    input  logic [VEC_W-1:0]   base_i,
    output logic               int_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic [N_LINES-1:0] pend_clr_o,
    output logic [N_LINES-1:0] isr_set_o,
    output logic [N_LINES-1:0] isr_clr_o
);

    localparam logic [LINE_W-1:0] SPUR_LINE = LINE_W'(N_LINES - 1);

    hs_state_e         state_q, state_d;
    logic              ack_q;
    logic              ack_rise;
    logic [LINE_W-1:0] line_q;
    logic              spur_first_q;
    logic              spur_final_q;
    logic              spur_now;
    logic              take_first;
    logic              take_second;
    logic              sel_spur;
    logic              drive;

    assign ack_rise    = ack_i && !ack_q;
    assign spur_now    = spur_first_q || !req_i[line_q];
    assign take_first  = (state_q == HS_ASSERT) && ack_rise;
    assign take_second = (state_q == HS_GAP) && ack_rise;

    // State register and handshake bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= HS_IDLE;
            ack_q        <= 1'b0;
            line_q       <= '0;
            spur_first_q <= 1'b0;
            spur_final_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ack_q   <= ack_i;
            if (take_first) begin
                line_q       <= win_valid_i ? win_line_i : SPUR_LINE;
                spur_first_q <= !win_valid_i;
            end
            if (take_second) spur_final_q <= spur_now;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE:   if (win_valid_i) state_d = HS_ASSERT;
            HS_ASSERT: if (ack_rise)    state_d = HS_PULSE1;
            HS_PULSE1: if (!ack_i)      state_d = HS_GAP;
            HS_GAP:    if (ack_rise)    state_d = HS_PULSE2;
            HS_PULSE2: if (!ack_i)      state_d = HS_IDLE;
            default:                    state_d = HS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        int_o      = (state_q == HS_ASSERT);
        pend_clr_o = '0;
        isr_set_o  = '0;
        isr_clr_o  = '0;
        sel_spur   = 1'b0;
        drive      = 1'b0;
        if (take_first && win_valid_i) begin
            pend_clr_o[win_line_i] = 1'b1;
            isr_set_o[win_line_i]  = 1'b1;
        end
        if (take_second && spur_now && !spur_first_q) isr_clr_o[line_q] = 1'b1;
        if (ack_i && state_q == HS_GAP) begin
            drive    = 1'b1;
            sel_spur = spur_now;
        end else if (ack_i && state_q == HS_PULSE2) begin
            drive    = 1'b1;
            sel_spur = spur_final_q;
        end
        vec_o = drive ? base_i + VEC_W'(sel_spur ? SPUR_LINE : line_q) : '0;
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int N_LINES  = 8,
    parameter int VEC_W    = 8,
    parameter int DEF_BASE = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_req,
    input  logic               irq_ack,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [VEC_W-1:0]   reg_wdata,
    output logic               irq_out,
    output logic [VEC_W-1:0]   vec_bus
);

    localparam int LINE_W = $clog2(N_LINES);

    logic [N_LINES-1:0] pend_w, pend_clr_w, mask_w, isr_w, isr_set_w, isr_clr_w;
    logic [VEC_W-1:0]   base_w;
    logic               win_valid_w;
    logic [LINE_W-1:0]  win_line_w;

    pic_edge_capture #(.N_LINES(N_LINES)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (irq_req),
        .clr_i  (pend_clr_w),
        .pend_o (pend_w)
    );

    pic_prio_resolve #(.N_LINES(N_LINES)) u_resolve (
        .pend_i  (pend_w),
        .mask_i  (mask_w),
        .isr_i   (isr_w),
        .valid_o (win_valid_w),
        .line_o  (win_line_w)
    );

    pic_regs #(.N_LINES(N_LINES), .VEC_W(VEC_W), .DEF_BASE(DEF_BASE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .isr_set_i (isr_set_w),
        .isr_clr_i (isr_clr_w),
        .mask_o    (mask_w),
        .base_o    (base_w),
        .isr_o     (isr_w)
    );

    pic_hs_fsm #(.N_LINES(N_LINES), .VEC_W(VEC_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_i       (irq_ack),
        .req_i       (irq_req),
        .win_valid_i (win_valid_w),
        .win_line_i  (win_line_w),
        .base_i      (base_w),
        .int_o       (irq_out),
        .vec_o       (vec_bus),
        .pend_clr_o  (pend_clr_w),
        .isr_set_o   (isr_set_w),
        .isr_clr_o   (isr_clr_w)
    );

endmodule

// File: rtl/prio_irq_ctrl_sva.sv
module prio_irq_ctrl_sva #(
    parameter int N_LINES = 8,
    parameter int VEC_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_ack,
    input logic               irq_out,
    input logic [VEC_W-1:0]   vec_bus,
    input logic               reg_wr,
    input logic [1:0]         reg_addr,
    input logic [VEC_W-1:0]   reg_wdata,
    input logic [N_LINES-1:0] isr
);

    a_r5_first_pulse_drops_int: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && $rose(irq_ack)) |=> !irq_out);

    a_r5_isr_no_growth_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out |=> ($countones(isr) <= $past($countones(isr))));

    a_r6_bus_quiet_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_ack |-> (vec_bus == '0));

    a_r6_bus_not_with_int: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_bus != '0) |-> !irq_out);

    a_r9_eos_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2 && !irq_out) |=>
            ((isr & $past(reg_wdata[N_LINES-1:0])) == '0));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_sva #(.N_LINES(N_LINES), .VEC_W(VEC_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_ack   (irq_ack),
    .irq_out   (irq_out),
    .vec_bus   (vec_bus),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .isr       (isr_w)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_req = '0;
    logic       irq_ack = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       irq_out;
    logic [7:0] vec_bus;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    bit    second  = 1'b0;
    int    exp_q[$];
    string tag_q[$];
    int    cur_exp = 0;
    string cur_tag = "";

    always #2.5 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .irq_ack   (irq_ack),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .irq_out   (irq_out),
        .vec_bus   (vec_bus)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic expect_int(input bit want, input string tag);
        repeat (5) tick();
        check(irq_out == want, tag, int'(irq_out), int'(want));
    endtask

    // Driver: full two-pulse exchange; pushes the expected vector for the monitor
    task automatic handshake(input int exp_vec, input string tag, input int drop_line);
        repeat (4) tick();
        check(irq_out == 1'b1, {tag, " int before ack"}, int'(irq_out), 1);
        irq_ack = 1'b1;
        tick(); tick();
        irq_ack = 1'b0;
        tick();
        check(irq_out == 1'b0, "R5 int dropped after first pulse", int'(irq_out), 0);
        check(vec_bus == 8'd0, "R6 bus idle between pulses", int'(vec_bus), 0);
        if (drop_line >= 0) irq_req[drop_line] = 1'b0;
        tick();
        exp_q.push_back(exp_vec);
        tag_q.push_back(tag);
        second  = 1'b1;
        irq_ack = 1'b1;
        tick(); tick();
        irq_ack = 1'b0;
        second  = 1'b0;
        tick(); tick();
    endtask

    // Monitor: compare vector bus during second pulse
    always @(negedge clk) begin
        if (second && irq_ack) begin
            if (exp_q.size() > 0) begin
                cur_exp = exp_q.pop_front();
                cur_tag = tag_q.pop_front();
            end
            check(vec_bus == cur_exp[7:0], cur_tag, int'(vec_bus), cur_exp);
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check(irq_out == 1'b0, "R1 reset irq_out", int'(irq_out), 0);
        check(vec_bus == 8'd0, "R1 reset vec_bus", int'(vec_bus), 0);

        // Single request, default base 32; then blocking and nesting
        irq_req[3] = 1'b1;
        expect_int(1'b1, "R2 edge raises int");
        handshake(35, "R1 R6 vector 32+3", -1);
        irq_req[5] = 1'b1;
        expect_int(1'b0, "R8 lower line blocked");
        irq_req[3] = 1'b0; tick(); irq_req[3] = 1'b1;
        expect_int(1'b0, "R8 same line blocked");
        irq_req[1] = 1'b1;
        expect_int(1'b1, "R8 higher line nests");
        handshake(33, "R8 nested vector", -1);
        wreg(2'd2, 8'h02);
        expect_int(1'b0, "R9 line3 still in service");
        wreg(2'd2, 8'h08);
        expect_int(1'b1, "R9 eos releases");
        handshake(35, "R2 re-edged line3 kept pending", -1);
        wreg(2'd2, 8'h08);
        handshake(37, "R4 line5 after line3", -1);
        wreg(2'd2, 8'h20);
        expect_int(1'b0, "R2 held lines no retrigger");
        irq_req = '0;
        tick();

        // Mask and priority order
        wreg(2'd0, 8'hFF);
        irq_req[6] = 1'b1; irq_req[2] = 1'b1; irq_req[4] = 1'b1;
        expect_int(1'b0, "R3 masked no int");
        wreg(2'd3, 8'h00);
        expect_int(1'b0, "R10 addr3 ignored");
        wreg(2'd0, 8'h00);
        expect_int(1'b1, "R3 unmask raises int");
        handshake(34, "R4 line2 first", -1);
        wreg(2'd2, 8'h04);
        handshake(36, "R4 line4 second", -1);
        wreg(2'd2, 8'h10);
        handshake(38, "R4 line6 third", -1);
        wreg(2'd2, 8'h40);
        irq_req = '0;
        tick();

        // Base register
        wreg(2'd1, 8'h60);
        irq_req[0] = 1'b1;
        handshake(8'h60, "R10 new base line0", -1);
        wreg(2'd2, 8'h01);
        irq_req = '0;
        tick();

        // Spurious: line drops between pulses
        irq_req[5] = 1'b1;
        handshake(8'h67, "R7 spurious vector", 5);
        irq_req[6] = 1'b1;
        expect_int(1'b1, "R7 isr released by spurious");
        handshake(8'h66, "R7 follow-up line6", -1);
        wreg(2'd2, 8'h40);
        irq_req = '0;
        repeat (3) tick();

        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule